// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets synchronous logic use a 32K x 8 asynchronous static RAM. A client asserts a request while the controller is idle and supplies a direction, an address and write data. The controller then runs exactly one device cycle. It drives the active-low chip-select, write-strobe and output-gate pins in sequence. It also decides, cycle by cycle, whether its own data drivers are enabled. When the cycle completes it returns a one-clock completion pulse, with registered read data for a read.

Every interval of the schedule is a whole number of system clocks. Each count is computed at elaboration as the ceiling of a nanosecond timing parameter divided by the clock period. The write strobe window is the longest of four limits: the pulse width, address valid to end of strobe, chip select to end of strobe, and data setup. Recovery clocks then pad the write up to the minimum write cycle. The read window is the longest of the address, chip-select and output-gate access times. A write whose previous operation was a read first waits out the device's output release time, with all strobes high and the drivers off. The data bus is modelled as separate in, out and enable pins, so the pad tristate stays outside the block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Out of reset and whenever idle, all three strobes are high (1), the data drivers are disabled (`sram_dq_oe`=0), `done` is 0 and `req_ready` is 1.
- R2: A write holds chip-select and write-strobe low together for PULSE clocks, with the output gate high throughout. During those clocks `sram_dq_out` carries the accepted write data with drivers enabled. The default of 8 ns per clock gives PULSE = 10.
- R3: After the write pulse, all strobes stay high for WREC clocks, 3 at the defaults, while the drivers keep the data. `done` then pulses, and a later read of that address returns the written byte.
- R4: A read holds chip-select and output gate low, with the write strobe high and the drivers off, for ACC clocks, 13 at the defaults. `rdata` takes the value on `sram_dq_in` during the last of those clocks. It is presented with `done` in the following clock and holds until the next read completes.
- R5: The address latched when a request is accepted appears on `sram_addr` for the whole cycle, including recovery. Changes on `req_addr` and `req_wdata` after acceptance have no effect.
- R6: A write whose previous operation was a read starts with TURN clocks, 5 at the defaults, in which all strobes are high and the drivers are off. The drivers are never enabled while the output gate is low.
- R7: `done` lasts exactly one clock. `req_ready` is 1 only in the idle state, and a request raised while busy is ignored and starts no cycle.
- R8: Every clock count equals the ceiling of its nanosecond parameter over the clock period, and elaboration stops if any count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request, accepted only while `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Registered read data |
| sram_addr | output | 15 | Device address |
| sram_ce_n | output | 1 | Device chip select, active low |
| sram_we_n | output | 1 | Device write strobe, active low |
| sram_oe_n | output | 1 | Device output gate, active low |
| sram_dq_out | output | 8 | Data toward the device |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 8 | Data from the device |

## Verification
The assertions assume that reset is asserted from time zero. They also assume the device puts valid data on `sram_dq_in` no later than the last clock of a read window. The bench's device model meets both: it updates the returned byte half a clock after the strobes change and holds it steady for the rest of the window. Requests are raised only on clocks where the bench expects the controller to be idle, apart from single deliberate pulses that fall mid-cycle. Those pulses, together with changes on the address and data inputs, check that a busy controller ignores them.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WPULSE,
        ST_WREC,
        ST_RACC,
        ST_RREC
    } seq_state_e;

    // whole clocks needed to cover t_ns, rounded up
    function automatic int ns_to_clk(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q > CNT_W'(1)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(1);
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

    // a phase of zero clocks cannot be timed
    p_load_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_data_lane.sv
module sram_data_lane #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (accept) begin
            lane_d.addr  = req_addr;
            lane_d.wdata = req_wdata;
        end
        if (capture) begin
            lane_d.rdata = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign addr   = lane_q.addr;
    assign dq_out = lane_q.wdata;
    assign rdata  = lane_q.rdata;

    // read data changes only on a capture clock
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata));

endmodule

// File: rtl/sram_cyc_seq.sv
module sram_cyc_seq
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int TURN_CYC  = 5,
    parameter int PULSE_CYC = 10,
    parameter int WREC_CYC  = 3,
    parameter int RACC_CYC  = 13,
    parameter int RREC_CYC  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic             t_last,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drive,
    output logic             done
);
    typedef struct packed {
        seq_state_e st;
        logic       last_rd;
        logic       done;
        logic       ce_n;
        logic       we_n;
        logic       oe_n;
        logic       drive;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept   = 1'b0;
        capture  = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    t_load = 1'b1;
                    if (!req_write) begin
                        s_d.st = ST_RACC;
                        t_val  = CNT_W'(RACC_CYC);
                    end else if (s_q.last_rd) begin
                        s_d.st = ST_TURN;
                        t_val  = CNT_W'(TURN_CYC);
                    end else begin
                        s_d.st = ST_WPULSE;
                        t_val  = CNT_W'(PULSE_CYC);
                    end
                end
            end
            ST_TURN: begin
                if (t_last) begin
                    s_d.st = ST_WPULSE;
                    t_load = 1'b1;
                    t_val  = CNT_W'(PULSE_CYC);
                end
            end
            ST_WPULSE: begin
                if (t_last) begin
                    s_d.st = ST_WREC;
                    t_load = 1'b1;
                    t_val  = CNT_W'(WREC_CYC);
                end
            end
            ST_WREC: begin
                if (t_last) begin
                    s_d.st      = ST_IDLE;
                    s_d.done    = 1'b1;
                    s_d.last_rd = 1'b0;
                end
            end
            ST_RACC: begin
                if (t_last) begin
                    capture     = 1'b1;
                    s_d.done    = 1'b1;
                    s_d.last_rd = 1'b1;
                    if (RREC_CYC > 0) begin
                        s_d.st = ST_RREC;
                        t_load = 1'b1;
                        t_val  = CNT_W'(RREC_CYC);
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            ST_RREC: begin
                if (t_last) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
        // pins are registered from the next state so they never glitch
        s_d.ce_n  = !(s_d.st == ST_WPULSE || s_d.st == ST_RACC);
        s_d.we_n  = (s_d.st != ST_WPULSE);
        s_d.oe_n  = (s_d.st != ST_RACC);
        s_d.drive = (s_d.st == ST_WPULSE || s_d.st == ST_WREC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, last_rd: 1'b0, done: 1'b0,
                     ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = (s_q.st == ST_IDLE);
    assign ce_n  = s_q.ce_n;
    assign we_n  = s_q.we_n;
    assign oe_n  = s_q.oe_n;
    assign drive = s_q.drive;
    assign done  = s_q.done;

    // checker counters: length of the write strobe, time since output gate rose
    logic [CNT_W-1:0] wl_cnt_q, rel_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_cnt_q  <= '0;
            rel_cnt_q <= CNT_W'(TURN_CYC);
        end else begin
            if (!we_n) wl_cnt_q <= (wl_cnt_q == '1) ? wl_cnt_q : wl_cnt_q + CNT_W'(1);
            else       wl_cnt_q <= '0;
            if (!oe_n)                              rel_cnt_q <= '0;
            else if (int'(rel_cnt_q) < TURN_CYC)    rel_cnt_q <= rel_cnt_q + CNT_W'(1);
        end
    end

    p_we_with_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));

    p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (int'(wl_cnt_q) >= PULSE_CYC));

    p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> oe_n);

    p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> (int'(rel_cnt_q) >= TURN_CYC));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 8,
    parameter int T_WC_NS   = 100,
    parameter int T_AW_NS   = 80,
    parameter int T_CW_NS   = 80,
    parameter int T_WP_NS   = 60,
    parameter int T_DW_NS   = 35,
    parameter int T_AA_NS   = 100,
    parameter int T_ACE_NS  = 100,
    parameter int T_OE_NS   = 50,
    parameter int T_RC_NS   = 100,
    parameter int T_REL_NS  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int C_WC   = ns_to_clk(T_WC_NS, CLK_NS);
    localparam int C_AW   = ns_to_clk(T_AW_NS, CLK_NS);
    localparam int C_CW   = ns_to_clk(T_CW_NS, CLK_NS);
    localparam int C_WP   = ns_to_clk(T_WP_NS, CLK_NS);
    localparam int C_DW   = ns_to_clk(T_DW_NS, CLK_NS);
    localparam int C_AA   = ns_to_clk(T_AA_NS, CLK_NS);
    localparam int C_ACE  = ns_to_clk(T_ACE_NS, CLK_NS);
    localparam int C_OE   = ns_to_clk(T_OE_NS, CLK_NS);
    localparam int C_RC   = ns_to_clk(T_RC_NS, CLK_NS);
    localparam int C_REL  = ns_to_clk(T_REL_NS, CLK_NS);

    localparam int PULSE_CYC = imax(imax(C_WP, C_AW), imax(C_CW, C_DW));
    localparam int WREC_CYC  = imax(C_WC - PULSE_CYC, 1);
    localparam int RACC_CYC  = imax(imax(C_AA, C_ACE), C_OE);
    localparam int RREC_CYC  = (C_RC > RACC_CYC) ? (C_RC - RACC_CYC) : 0;
    localparam int TURN_CYC  = C_REL;
    localparam int MAX_CYC   = imax(imax(PULSE_CYC, WREC_CYC),
                                    imax(imax(RACC_CYC, RREC_CYC), TURN_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    generate
        if (CLK_NS < 1 || C_WC < 1 || C_AW < 1 || C_CW < 1 || C_WP < 1 ||
            C_DW < 1 || C_AA < 1 || C_ACE < 1 || C_OE < 1 || C_RC < 1 ||
            C_REL < 1) begin : g_bad_timing
            $fatal(1, "sram_cycle_ctrl: a timing count rounds to zero clocks");
        end
    endgenerate

    logic             t_last, t_load, accept, capture;
    logic [CNT_W-1:0] t_val;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    sram_cyc_seq #(
        .CNT_W     (CNT_W),
        .TURN_CYC  (TURN_CYC),
        .PULSE_CYC (PULSE_CYC),
        .WREC_CYC  (WREC_CYC),
        .RACC_CYC  (RACC_CYC),
        .RREC_CYC  (RREC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .t_last    (t_last),
        .ready     (req_ready),
        .accept    (accept),
        .capture   (capture),
        .t_load    (t_load),
        .t_val     (t_val),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .drive     (sram_dq_oe),
        .done      (done)
    );

    sram_data_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .addr      (sram_addr),
        .dq_out    (sram_dq_out),
        .rdata     (rdata)
    );

    // address stays put while the device is selected
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // drivers only come on as part of a write
    p_drive_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (!sram_we_n && !sram_ce_n));

endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;

    localparam int PULSE = 10;
    localparam int WREC  = 3;
    localparam int ACC   = 13;
    localparam int TURN  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    always #4 clk = ~clk;

    sram_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    typedef struct {
        bit          ce_n, we_n, oe_n, drv, dn, rdy, use_adr, use_rd;
        logic [14:0] adr;
        logic [7:0]  wd, rd;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          failures = 0;
    bit          last_rd = 0;
    logic [7:0]  dev_mem [logic [14:0]];
    logic [7:0]  mdl_mem [logic [14:0]];

    function automatic logic [7:0] fill(input logic [14:0] a);
        return a[7:0] ^ a[14:7] ^ 8'h3C;
    endfunction

    function automatic exp_t mk(bit ce, bit we, bit oe, bit drv, bit dn,
                                bit rdy, string tag);
        exp_t e;
        e.ce_n = ce; e.we_n = we; e.oe_n = oe; e.drv = drv; e.dn = dn;
        e.rdy = rdy; e.use_adr = 0; e.use_rd = 0; e.adr = '0; e.wd = '0;
        e.rd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: compare against the model, then update the device model
    task automatic tick();
        exp_t e;
        @(negedge clk);
        e = (q.size() != 0) ? q.pop_front() : mk(1, 1, 1, 0, 0, 1, "R1 R7 idle");
        check(sram_ce_n == e.ce_n, e.tag, "ce_n", int'(sram_ce_n), int'(e.ce_n));
        check(sram_we_n == e.we_n, e.tag, "we_n", int'(sram_we_n), int'(e.we_n));
        check(sram_oe_n == e.oe_n, e.tag, "oe_n", int'(sram_oe_n), int'(e.oe_n));
        check(sram_dq_oe == e.drv, e.tag, "dq_oe", int'(sram_dq_oe), int'(e.drv));
        check(done == e.dn, e.tag, "done", int'(done), int'(e.dn));
        check(req_ready == e.rdy, e.tag, "ready", int'(req_ready), int'(e.rdy));
        if (e.use_adr)
            check(sram_addr == e.adr, "R5", "addr", int'(sram_addr), int'(e.adr));
        if (e.drv)
            check(sram_dq_out == e.wd, e.tag, "dq_out", int'(sram_dq_out), int'(e.wd));
        if (e.use_rd)
            check(rdata == e.rd, "R4", "rdata", int'(rdata), int'(e.rd));
        if (!sram_ce_n && !sram_we_n && sram_dq_oe)
            dev_mem[sram_addr] = sram_dq_out;
        if (!sram_ce_n && !sram_oe_n && sram_we_n)
            sram_dq_in = dev_mem.exists(sram_addr) ? dev_mem[sram_addr] : fill(sram_addr);
        else
            sram_dq_in = 8'hEE;
    endtask

    task automatic run_op(bit wr, logic [14:0] a, logic [7:0] d, bit poke);
        exp_t e;
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            if (last_rd)
                for (int i = 0; i < TURN; i++) q.push_back(mk(1, 1, 1, 0, 0, 0, "R6 turnaround"));
            for (int i = 0; i < PULSE; i++) begin
                e = mk(0, 0, 1, 1, 0, 0, "R2 R8 pulse");
                e.use_adr = 1; e.adr = a; e.wd = d;
                q.push_back(e);
            end
            for (int i = 0; i < WREC; i++) begin
                e = mk(1, 1, 1, 1, 0, 0, "R3 recovery");
                e.use_adr = 1; e.adr = a; e.wd = d;
                q.push_back(e);
            end
            q.push_back(mk(1, 1, 1, 0, 1, 1, "R3 R7 write done"));
            mdl_mem[a] = d;
            last_rd = 0;
        end else begin
            for (int i = 0; i < ACC; i++) begin
                e = mk(0, 1, 0, 0, 0, 0, "R4 R8 access");
                e.use_adr = 1; e.adr = a;
                q.push_back(e);
            end
            e = mk(1, 1, 1, 0, 1, 1, "R4 R7 read done");
            e.use_rd = 1;
            e.rd = mdl_mem.exists(a) ? mdl_mem[a] : fill(a);
            q.push_back(e);
            last_rd = 1;
        end
        tick();
        req = 1'b0;
        req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        if (poke) begin
            tick(); tick();
            req = 1'b1;
            tick();
            req = 1'b0;
        end
        while (q.size() != 0) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(); tick();
        run_op(1, 15'h0123, 8'hA5, 0);
        run_op(0, 15'h0123, 8'h00, 0);
        run_op(0, 15'h2222, 8'h00, 0);
        run_op(1, 15'h2222, 8'h5A, 0);
        run_op(1, 15'h0000, 8'hFF, 0);
        run_op(1, 15'h7FFF, 8'h00, 1);
        tick(); tick();
        run_op(0, 15'h7FFF, 8'h11, 1);
        run_op(0, 15'h0000, 8'h22, 0);
        run_op(0, 15'h2222, 8'h33, 0);
        tick();
        run_op(1, 15'h4C3D, 8'h96, 1);
        run_op(0, 15'h4C3D, 8'h00, 0);
        repeat (3) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R7 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule